// File: doc/BRIEF.md
# Debug Bus Access Register Bridge

This block is the debug-bus access data register that sits behind a test-access-port scan chain. The scan logic shifts in a word and pulses an update strobe. On that strobe the bridge splits the word into an operation code, a 32-bit data field and an address field, and stores the whole word as the pending response. For a read or a write, it then starts one transfer on a plain valid/ready request bus. The next capture scan sees the stored word, with the status code placed where the operation code was.

When a read succeeds, the returned value is written into the data field of the stored response, so the following scan carries it out. A failed transfer leaves the shifted data in place and reports the failed code. While a transfer is outstanding, the captured status reads busy. An update that arrives during that time is dropped and latches a sticky busy flag. From then on, every update is refused and every capture reports busy. This lasts until the control register logic pulses the clear input.

Top module: `dbr_bridge`

## Requirements
- R1: After the synchronous reset, `cap_word` is all zeros, `req_valid` is 0 and `busy_sticky` is 0.
- R2: The word has three fields: operation code in bits 1:0, data in bits 33:2, and address in bits ABITS+33:34. A capture returns the stored address and data in those same positions, with the status code in bits 1:0.
- R3: An accepted update with operation 1 (read) raises `req_valid` one cycle later, with `req_write`=0 and `req_addr` equal to the address field. Address and control then stay unchanged until a cycle in which `bus_ready` is 1.
- R4: An accepted update with operation 2 (write) raises `req_valid` one cycle later, with `req_write`=1, `req_addr` equal to the address field and `req_wdata` equal to the data field.
- R5: An accepted update with operation 0 (no-op) or 3 (reserved) starts no request. The next capture returns the shifted address and data with status 0 (success).
- R6: In every cycle in which `req_valid` is 1, the status bits of `cap_word` read 3 (busy).
- R7: A transfer that ends with `bus_ready`=1 and `bus_err`=0 sets the status to 0. For a read, the data field becomes `bus_rdata`. For a write, the data field keeps the written value.
- R8: A transfer that ends with `bus_err`=1 sets the status to 2 (failed), and the data field keeps the shifted value.
- R9: An update while `req_valid` is 1 changes no request output and no stored field. It sets `busy_sticky` to 1.
- R10: While `busy_sticky` is 1, the status bits of `cap_word` read 3 and updates are ignored. Only a `clr_sticky` pulse clears the flag, after which the stored status shows again and updates are accepted.
- R11: `req_valid` falls in the cycle after the handshake cycle. Each accepted update starts at most one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Update strobe from the scan logic, one cycle |
| shift_word | input | ABITS+34 | Word shifted in by the scan chain |
| clr_sticky | input | 1 | Clear pulse for the sticky busy flag, from the control register |
| cap_word | output | ABITS+34 | Word presented to the next capture |
| busy_sticky | output | 1 | Sticky busy flag |
| req_valid | output | 1 | Bus request valid |
| req_write | output | 1 | Bus request is a write |
| req_addr | output | ABITS | Bus request address |
| req_wdata | output | 32 | Bus write data |
| bus_ready | input | 1 | Bus accepts and completes the request this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| bus_err | input | 1 | Transfer failed, valid with `bus_ready` |

## Verification
The bench builds the bridge with ABITS at its default of 7, which gives a 41-bit word. With that size the table can place address patterns that set every address bit, including the top bit 40, and all-ones and single-bit data patterns. This shows that no field edge is off by one. Handshake delays of zero to three cycles cover both a same-cycle completion and a long wait, where busy must hold and the request must stay stable. All four operation codes and both error outcomes appear in the table.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } dbr_op_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_RSVD = 2'd1,
    ST_FAIL = 2'd2,
    ST_BUSY = 2'd3
  } dbr_st_e;

  localparam int OP_W  = 2;
  localparam int DAT_W = 32;

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
#(
  parameter int ABITS = 7,
  parameter int DW    = DAT_W,
  localparam int W    = ABITS + DW + OP_W
) (
  input  logic [W-1:0]     word,
  output logic [OP_W-1:0]  op,
  output logic [DW-1:0]    data,
  output logic [ABITS-1:0] addr,
  output logic             is_rd,
  output logic             is_wr
);

  localparam int D_LO = OP_W;
  localparam int A_LO = OP_W + DW;

  always_comb begin
    op    = word[OP_W-1:0];
    data  = word[D_LO +: DW];
    addr  = word[A_LO +: ABITS];
    is_rd = (op == OP_READ);
    is_wr = (op == OP_WRITE);
  end

endmodule

// File: rtl/dbr_bus_port.sv
module dbr_bus_port
  import dbr_pkg::*;
#(
  parameter int ABITS = 7,
  parameter int DW    = DAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [ABITS-1:0] start_addr,
  input  logic [DW-1:0]    start_wdata,
  output logic             req_valid,
  output logic             req_write,
  output logic [ABITS-1:0] req_addr,
  output logic [DW-1:0]    req_wdata,
  input  logic             bus_ready,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_err,
  output logic             done,
  output logic             done_err,
  output logic             done_rd,
  output logic [DW-1:0]    done_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (req_valid && bus_ready) begin
      req_valid <= 1'b0;
    end else if (start && !req_valid) begin
      req_valid <= 1'b1;
      req_write <= start_wr;
      req_addr  <= start_addr;
      req_wdata <= start_wdata;
    end
  end

  always_comb begin
    done       = req_valid && bus_ready;
    done_err   = bus_err;
    done_rd    = !req_write;
    done_rdata = bus_rdata;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !bus_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)) // R3
    else $error("request changed while waiting");

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    req_valid && bus_ready |=> !req_valid) // R11
    else $error("request held after handshake");

endmodule

// File: rtl/dbr_resp_store.sv
module dbr_resp_store
  import dbr_pkg::*;
#(
  parameter int ABITS = 7,
  parameter int DW    = DAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OP_W-1:0]  load_op,
  input  logic             load_acc,
  input  logic [DW-1:0]    load_data,
  input  logic [ABITS-1:0] load_addr,
  input  logic             done,
  input  logic             done_err,
  input  logic             done_rd,
  input  logic [DW-1:0]    done_rdata,
  output logic [OP_W-1:0]  st_op,
  output logic [DW-1:0]    st_data,
  output logic [ABITS-1:0] st_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_op   <= ST_OK;
      st_data <= '0;
      st_addr <= '0;
    end else if (load) begin
      st_addr <= load_addr;
      st_data <= load_data;
      st_op   <= load_acc ? load_op : OP_W'(ST_OK);
    end else if (done) begin
      st_op <= done_err ? OP_W'(ST_FAIL) : OP_W'(ST_OK);
      if (done_rd && !done_err) st_data <= done_rdata;
    end
  end

  AST_FAIL_KEEP: assert property (@(posedge clk) disable iff (rst)
    done && done_err && !load |=> st_op == ST_FAIL && $stable(st_data)) // R8
    else $error("failed transfer did not keep data");

endmodule

// File: rtl/dbr_bridge.sv
module dbr_bridge
  import dbr_pkg::*;
#(
  parameter int ABITS = 7,
  localparam int DW   = DAT_W,
  localparam int W    = ABITS + DW + OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [W-1:0]     shift_word,
  input  logic             clr_sticky,
  output logic [W-1:0]     cap_word,
  output logic             busy_sticky,
  output logic             req_valid,
  output logic             req_write,
  output logic [ABITS-1:0] req_addr,
  output logic [DW-1:0]    req_wdata,
  input  logic             bus_ready,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_err
);

  localparam int A_LO = OP_W + DW;

  logic [OP_W-1:0]  dec_op;
  logic [DW-1:0]    dec_data;
  logic [ABITS-1:0] dec_addr;
  logic             dec_rd, dec_wr;
  logic             accept, start;
  logic             done, done_err, done_rd;
  logic [DW-1:0]    done_rdata;
  logic [OP_W-1:0]  st_op;
  logic [DW-1:0]    st_data;
  logic [ABITS-1:0] st_addr;

  dbr_decode #(.ABITS(ABITS), .DW(DW)) u_dec (
    .word(shift_word), .op(dec_op), .data(dec_data), .addr(dec_addr),
    .is_rd(dec_rd), .is_wr(dec_wr)
  );

  always_comb begin
    accept = upd && !req_valid && !busy_sticky;
    start  = accept && (dec_rd || dec_wr);
  end

  dbr_bus_port #(.ABITS(ABITS), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .start(start), .start_wr(dec_wr),
    .start_addr(dec_addr), .start_wdata(dec_data),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .done(done), .done_err(done_err), .done_rd(done_rd),
    .done_rdata(done_rdata)
  );

  dbr_resp_store #(.ABITS(ABITS), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .load(accept), .load_op(dec_op),
    .load_acc(dec_rd || dec_wr), .load_data(dec_data), .load_addr(dec_addr),
    .done(done), .done_err(done_err), .done_rd(done_rd),
    .done_rdata(done_rdata), .st_op(st_op), .st_data(st_data),
    .st_addr(st_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)                   busy_sticky <= 1'b0;
    else if (clr_sticky)       busy_sticky <= 1'b0;
    else if (upd && req_valid) busy_sticky <= 1'b1;
  end

  always_comb begin
    cap_word = {st_addr, st_data,
                (req_valid || busy_sticky) ? OP_W'(ST_BUSY) : st_op};
  end

  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    upd && !req_valid && !busy_sticky && !clr_sticky &&
    (shift_word[1:0] == OP_NOP || shift_word[1:0] == OP_RSVD)
    |=> !req_valid && cap_word[1:0] == ST_OK) // R5
    else $error("no-op update misbehaved");

  AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    upd && !req_valid && !busy_sticky && shift_word[1:0] == OP_WRITE
    |=> req_valid && req_write && req_wdata == $past(shift_word[A_LO-1:OP_W])
        && req_addr == $past(shift_word[W-1:A_LO])) // R4
    else $error("write request fields wrong");

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    upd && req_valid && !clr_sticky |=> busy_sticky) // R9
    else $error("sticky busy not set");

  AST_STICKY_CLR: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_sticky) |-> $past(clr_sticky)) // R10
    else $error("sticky busy cleared without request");

  AST_RD_MERGE: assert property (@(posedge clk) disable iff (rst)
    req_valid && bus_ready && !bus_err && !req_write && !busy_sticky && !upd
    |=> cap_word[A_LO-1:OP_W] == $past(bus_rdata) && cap_word[1:0] == ST_OK) // R7
    else $error("read data not merged");

  AST_FAIL_CAP: assert property (@(posedge clk) disable iff (rst)
    req_valid && bus_ready && bus_err && !busy_sticky && !upd
    |=> cap_word[1:0] == ST_FAIL) // R8
    else $error("failed status missing");

endmodule

// File: tb/sim_dbr_bridge.sv
`timescale 1ns/1ps
module sim_dbr_bridge;

  localparam int AB = 7;
  localparam int W  = AB + 34;
  localparam int NV = 8;

  localparam logic [1:0]    V_OP  [NV] = '{2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};
  localparam logic [AB-1:0] V_AD  [NV] = '{7'h05, 7'h7F, 7'h12, 7'h40, 7'h00, 7'h33, 7'h01, 7'h2A};
  localparam logic [31:0]   V_DAT [NV] = '{32'h1111_1111, 32'hA5A5_5A5A, 32'h0000_FFFF, 32'h1234_5678,
                                          32'hFFFF_FFFF, 32'h0BAD_F00D, 32'h0000_0000, 32'h0000_0001};
  localparam int            V_DLY [NV] = '{0, 2, 0, 1, 0, 0, 3, 0};
  localparam logic          V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0]   V_RD  [NV] = '{32'hCAFE_0123, 32'h0, 32'h0, 32'h0000_9999,
                                          32'h0, 32'h0, 32'h8000_0001, 32'h0};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd = 1'b0;
  logic [W-1:0]  shift_word = '0;
  logic          clr_sticky = 1'b0;
  logic [W-1:0]  cap_word;
  logic          busy_sticky;
  logic          req_valid, req_write;
  logic [AB-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          bus_ready = 1'b0;
  logic [31:0]   bus_rdata = '0;
  logic          bus_err = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  dbr_bridge #(.ABITS(AB)) u0 (
    .clk(clk), .rst(rst), .upd(upd), .shift_word(shift_word),
    .clr_sticky(clr_sticky), .cap_word(cap_word), .busy_sticky(busy_sticky),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_err(bus_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic upd_pulse(input logic [1:0] op, input logic [AB-1:0] ad, input logic [31:0] dt);
    shift_word = {ad, dt, op};
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic serve(input int dly, input logic err, input logic [31:0] rd);
    for (int i = 0; i < dly; i++) begin
      chk("R6 busy while waiting", {62'd0, cap_word[1:0]}, 64'd3);
      @(negedge clk);
    end
    bus_ready = 1'b1;
    bus_err   = err;
    bus_rdata = rd;
    @(negedge clk);
    bus_ready = 1'b0;
    bus_err   = 1'b0;
    bus_rdata = '0;
    chk("R11 valid drops after handshake", {63'd0, req_valid}, 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !ended) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] exp_w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cap_word after reset", {23'd0, cap_word}, 64'd0);
    chk("R1 req_valid after reset", {63'd0, req_valid}, 64'd0);
    chk("R1 busy_sticky after reset", {63'd0, busy_sticky}, 64'd0);

    // table of transactions
    for (int v = 0; v < NV; v++) begin
      logic acc;
      acc = (V_OP[v] == 2'd1) || (V_OP[v] == 2'd2);
      upd_pulse(V_OP[v], V_AD[v], V_DAT[v]);
      if (acc) begin
        chk("R3 req_valid raised", {63'd0, req_valid}, 64'd1);
        chk("R3 req_addr", {57'd0, req_addr}, {57'd0, V_AD[v]});
        chk("R4 req_write", {63'd0, req_write}, {63'd0, V_OP[v] == 2'd2});
        if (V_OP[v] == 2'd2) chk("R4 req_wdata", {32'd0, req_wdata}, {32'd0, V_DAT[v]});
        serve(V_DLY[v], V_ERR[v], V_RD[v]);
        exp_w = {V_AD[v], (V_OP[v] == 2'd1 && !V_ERR[v]) ? V_RD[v] : V_DAT[v],
                 V_ERR[v] ? 2'd2 : 2'd0};
        if (V_ERR[v]) chk("R8 failed capture", {23'd0, cap_word}, {23'd0, exp_w});
        else          chk("R7 R2 success capture", {23'd0, cap_word}, {23'd0, exp_w});
      end else begin
        chk("R5 no request", {63'd0, req_valid}, 64'd0);
        exp_w = {V_AD[v], V_DAT[v], 2'd0};
        chk("R5 R2 no-op capture", {23'd0, cap_word}, {23'd0, exp_w});
      end
    end

    // R9: update during outstanding read
    upd_pulse(2'd1, 7'h10, 32'h0000_0042);
    upd_pulse(2'd2, 7'h22, 32'h0000_0077);
    chk("R9 ignored update keeps req_write", {63'd0, req_write}, 64'd0);
    chk("R9 ignored update keeps req_addr", {57'd0, req_addr}, 64'h10);
    chk("R9 sticky set", {63'd0, busy_sticky}, 64'd1);
    serve(1, 1'b0, 32'h5555_AAAA);
    chk("R10 sticky capture busy", {62'd0, cap_word[1:0]}, 64'd3);
    // R10: update refused while sticky
    upd_pulse(2'd2, 7'h22, 32'h0000_0077);
    chk("R10 no request while sticky", {63'd0, req_valid}, 64'd0);
    clr_sticky = 1'b1;
    @(negedge clk);
    clr_sticky = 1'b0;
    chk("R10 sticky cleared", {63'd0, busy_sticky}, 64'd0);
    exp_w = {7'h10, 32'h5555_AAAA, 2'd0};
    chk("R10 R9 stored read result intact", {23'd0, cap_word}, {23'd0, exp_w});
    upd_pulse(2'd2, 7'h22, 32'h0000_0077);
    chk("R10 update accepted after clear", {63'd0, req_valid}, 64'd1);
    serve(0, 1'b0, 32'h0);
    exp_w = {7'h22, 32'h0000_0077, 2'd0};
    chk("R7 write after clear", {23'd0, cap_word}, {23'd0, exp_w});

    // R1: reset in the middle of a transfer
    upd_pulse(2'd1, 7'h3C, 32'h0000_0003);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-transfer reset valid", {63'd0, req_valid}, 64'd0);
    chk("R1 mid-transfer reset cap", {23'd0, cap_word}, 64'd0);

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule